// File: doc/BRIEF.md
# Debug Hart Selection Control Register

This block is the main control word of a debug module. A debugger reaches it over a simple register bus with an address, a write enable, write data and combinational read data. The word holds a hart index and a small set of request bits. Those requests fan out to a parameterised number of harts as per-hart halt levels, hart reset levels and one-cycle resume pulses. Each hart also has a sticky have-reset flag, which the debugger acknowledges.

The index field keeps only the low `HARTSELLEN` bits, where `HARTSELLEN` is a parameter from 0 to 10. Bits above that read back as zero. A debugger finds the implemented width by writing ones to the whole field and counting the consecutive ones it reads back, starting at the least significant bit. Every request applies to the single hart named by the index in the same write. An index at or above the number of harts selects nothing.

A module-active bit gates everything else. While it is clear, all other state is held at its reset value and writes to other fields are dropped. Clearing and then setting it reinitialises the block. A read-only info word reports how many data words are available.

Top module: `dbg_hart_ctl`

## Requirements
- R1: After the synchronous active-high reset, the control word at address 0x10 reads 0 and every per-hart output, `ndm_reset_o` and `dm_active_o` are 0.
- R2: Bit 0 of the control word is module-active. While it is 0, a write updates only that bit, and the other fields keep reading 0. A write with bit 0 clear returns every field and output to its reset value. A write that sets it reads back 1 in the next cycle.
- R3: The hart index occupies bits 25:16. Only the low HARTSELLEN bits are stored, and the bits above them read 0. Writing all ones to the field therefore reads back exactly HARTSELLEN consecutive ones from bit 16 upward.
- R4: Bit 31 (halt request) is a level stored per hart. A write sets or clears it only for the hart its index names, and other harts keep their level. Bit 31 reads back the level of the hart currently indexed.
- R5: Writing 1 to bit 30 (resume request) produces a one-cycle pulse on `resume_req_o`, in the cycle after the write, for the indexed hart, and only if its `halted_i` bit was 1. Bit 30 always reads 0.
- R6: Bit 29 (hart reset) is a per-hart level on `hart_reset_o` for the indexed hart. It reads back as the indexed hart's level.
- R7: When a hart's reset level falls, its `have_reset_o` bit becomes 1. Writing 1 to bit 28 clears `have_reset_o` only for the indexed hart. Bit 28 always reads 0.
- R8: An index value of NHARTS or more selects no hart. Requests written with such an index leave every per-hart output unchanged.
- R9: Bit 26 (array-select mode) is not implemented and reads 0. Bit 1 is a stored level that drives `ndm_reset_o`.
- R10: Address 0x12 reads the data-word count in bits 15:12, limited to 12, with all other bits 0. Any address other than 0x10 and 0x12 reads 0.
- R11: `bus_rdata` follows `bus_addr` and the current register state combinationally, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| halted_i | input | NHARTS | Per-hart halted status |
| halt_req_o | output | NHARTS | Per-hart halt request level |
| resume_req_o | output | NHARTS | Per-hart resume pulse |
| hart_reset_o | output | NHARTS | Per-hart reset level |
| have_reset_o | output | NHARTS | Per-hart sticky have-reset flag |
| ndm_reset_o | output | 1 | Reset level for the rest of the system |
| dm_active_o | output | 1 | Module-active level |

## Verification
Each stored field and each per-hart level changes at the clock edge that accepts the write, so it is due in the cycle after the write. The bench therefore queues its expectations right after that edge and compares them at the following falling edge. A resume pulse is checked in that same cycle and again one cycle later, to confirm it lasts exactly one cycle. Read data involves no register, so the bench compares a read in the same cycle the address is driven.

// File: rtl/dbgctl_pkg.sv
package dbgctl_pkg;

    localparam int unsigned BUS_AW   = 7;
    localparam int unsigned SEL_MAXW = 10;

    localparam logic [BUS_AW-1:0] CTRL_ADDR = 7'h10;
    localparam logic [BUS_AW-1:0] INFO_ADDR = 7'h12;

    localparam int unsigned POS_HALT    = 31;
    localparam int unsigned POS_RESUME  = 30;
    localparam int unsigned POS_HRESET  = 29;
    localparam int unsigned POS_ACK     = 28;
    localparam int unsigned POS_ARRAY   = 26;
    localparam int unsigned POS_SEL     = 16;
    localparam int unsigned POS_NDM     = 1;
    localparam int unsigned POS_ACTIVE  = 0;
    localparam int unsigned POS_DSZ     = 12;
    localparam int unsigned DSZ_LIMIT   = 12;

    typedef struct packed {
        logic                halt;
        logic                resume;
        logic                hreset;
        logic                ack;
        logic [SEL_MAXW-1:0] sel;
        logic                ndm;
        logic                active;
    } ctrl_fields_t;

    typedef struct packed {
        logic                halt;
        logic                resume;
        logic                hreset;
        logic                ack;
        logic [SEL_MAXW-1:0] sel;
    } hart_cmd_t;

    function automatic ctrl_fields_t split_ctrl(input logic [31:0] w);
        ctrl_fields_t f;
        f.halt   = w[POS_HALT];
        f.resume = w[POS_RESUME];
        f.hreset = w[POS_HRESET];
        f.ack    = w[POS_ACK];
        f.sel    = w[POS_SEL +: SEL_MAXW];
        f.ndm    = w[POS_NDM];
        f.active = w[POS_ACTIVE];
        return f;
    endfunction

    function automatic logic [3:0] clamp_dsz(input int unsigned n);
        return (n > DSZ_LIMIT) ? 4'(DSZ_LIMIT) : 4'(n);
    endfunction

endpackage

// File: rtl/dbgctl_ctrl_reg.sv
module dbgctl_ctrl_reg
    import dbgctl_pkg::*;
#(
    parameter int unsigned HARTSELLEN = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  ctrl_fields_t        wr_f,
    output logic                active_o,
    output logic                ndm_o,
    output logic [SEL_MAXW-1:0] sel_o,
    output logic                apply_o,
    output logic                clear_o,
    output hart_cmd_t           cmd_o
);

    localparam logic [SEL_MAXW-1:0] SEL_MASK = SEL_MAXW'((1 << HARTSELLEN) - 1);

    logic active_q;
    logic ndm_q;
    logic live_wr;

    assign live_wr = wr_en && active_q && wr_f.active;
    assign clear_o = wr_en && !wr_f.active;
    assign apply_o = live_wr;

    always_comb begin
        cmd_o.halt   = wr_f.halt;
        cmd_o.resume = wr_f.resume;
        cmd_o.hreset = wr_f.hreset;
        cmd_o.ack    = wr_f.ack;
        cmd_o.sel    = wr_f.sel & SEL_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            ndm_q    <= 1'b0;
        end else begin
            if (wr_en)
                active_q <= wr_f.active;
            if (clear_o)
                ndm_q <= 1'b0;
            else if (live_wr)
                ndm_q <= wr_f.ndm;
        end
    end

    generate
        if (HARTSELLEN == 0) begin : g_nosel
            assign sel_o = '0;
        end else begin : g_sel
            logic [HARTSELLEN-1:0] sel_q;
            always_ff @(posedge clk) begin
                if (rst || clear_o)
                    sel_q <= '0;
                else if (live_wr)
                    sel_q <= wr_f.sel[HARTSELLEN-1:0];
            end
            assign sel_o = SEL_MAXW'(sel_q);
        end
    endgenerate

    assign active_o = active_q;
    assign ndm_o    = ndm_q;

    assert_sel_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (sel_o & ~SEL_MASK) == '0);

    assert_inactive_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !active_o |-> (ndm_o == 1'b0 && sel_o == '0));

endmodule

// File: rtl/dbgctl_hart_fanout.sv
module dbgctl_hart_fanout
    import dbgctl_pkg::*;
#(
    parameter int unsigned NHARTS = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                apply_i,
    input  logic                clear_i,
    input  hart_cmd_t           cmd_i,
    input  logic [SEL_MAXW-1:0] view_sel_i,
    input  logic [NHARTS-1:0]   halted_i,
    output logic [NHARTS-1:0]   halt_req_o,
    output logic [NHARTS-1:0]   resume_req_o,
    output logic [NHARTS-1:0]   hart_reset_o,
    output logic [NHARTS-1:0]   have_reset_o,
    output logic                view_halt_o,
    output logic                view_hreset_o
);

    logic [NHARTS-1:0] halt_q, resume_q, hreset_q, have_q;

    generate
        for (genvar h = 0; h < NHARTS; h++) begin : g_hart
            logic hit;
            assign hit = apply_i && (cmd_i.sel == SEL_MAXW'(h));

            always_ff @(posedge clk) begin
                if (rst || clear_i) begin
                    halt_q[h]   <= 1'b0;
                    resume_q[h] <= 1'b0;
                    hreset_q[h] <= 1'b0;
                    have_q[h]   <= 1'b0;
                end else begin
                    resume_q[h] <= hit && cmd_i.resume && halted_i[h];
                    if (hit) begin
                        halt_q[h]   <= cmd_i.halt;
                        hreset_q[h] <= cmd_i.hreset;
                    end
                    if (hit && hreset_q[h] && !cmd_i.hreset)
                        have_q[h] <= 1'b1;
                    else if (hit && cmd_i.ack)
                        have_q[h] <= 1'b0;
                end
            end
        end
    endgenerate

    always_comb begin
        view_halt_o   = 1'b0;
        view_hreset_o = 1'b0;
        for (int h = 0; h < int'(NHARTS); h++) begin
            if (view_sel_i == SEL_MAXW'(h)) begin
                view_halt_o   = halt_q[h];
                view_hreset_o = hreset_q[h];
            end
        end
    end

    assign halt_req_o   = halt_q;
    assign resume_req_o = resume_q;
    assign hart_reset_o = hreset_q;
    assign have_reset_o = have_q;

    assert_resume_single_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(resume_req_o));

    assert_resume_halted_R5: assert property (@(posedge clk) disable iff (rst)
        (resume_req_o & ~$past(halted_i)) == '0);

    assert_halt_needs_write_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(apply_i) && !$past(clear_i)) |-> $stable(halt_req_o));

    assert_clear_zeroes_R2: assert property (@(posedge clk) disable iff (rst)
        $past(clear_i) |-> (halt_req_o == '0 && hart_reset_o == '0 && have_reset_o == '0));

endmodule

// File: rtl/dbg_hart_ctl.sv
module dbg_hart_ctl
    import dbgctl_pkg::*;
#(
    parameter int unsigned HARTSELLEN = 3,
    parameter int unsigned NHARTS     = 5,
    parameter int unsigned DATA_WORDS = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [6:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NHARTS-1:0] halted_i,
    output logic [NHARTS-1:0] halt_req_o,
    output logic [NHARTS-1:0] resume_req_o,
    output logic [NHARTS-1:0] hart_reset_o,
    output logic [NHARTS-1:0] have_reset_o,
    output logic              ndm_reset_o,
    output logic              dm_active_o
);

    localparam logic [3:0] DSZ_VAL = clamp_dsz(DATA_WORDS);

    ctrl_fields_t        wf;
    hart_cmd_t           cmd;
    logic                ctrl_wr, apply, clear;
    logic                active, ndm;
    logic [SEL_MAXW-1:0] sel;
    logic                view_halt, view_hreset;

    assign wf      = split_ctrl(bus_wdata);
    assign ctrl_wr = bus_we && (bus_addr == CTRL_ADDR);

    dbgctl_ctrl_reg #(.HARTSELLEN(HARTSELLEN)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ctrl_wr),
        .wr_f     (wf),
        .active_o (active),
        .ndm_o    (ndm),
        .sel_o    (sel),
        .apply_o  (apply),
        .clear_o  (clear),
        .cmd_o    (cmd)
    );

    dbgctl_hart_fanout #(.NHARTS(NHARTS)) u_fan (
        .clk           (clk),
        .rst           (rst),
        .apply_i       (apply),
        .clear_i       (clear),
        .cmd_i         (cmd),
        .view_sel_i    (sel),
        .halted_i      (halted_i),
        .halt_req_o    (halt_req_o),
        .resume_req_o  (resume_req_o),
        .hart_reset_o  (hart_reset_o),
        .have_reset_o  (have_reset_o),
        .view_halt_o   (view_halt),
        .view_hreset_o (view_hreset)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata[POS_HALT]              = view_halt;
            bus_rdata[POS_HRESET]            = view_hreset;
            bus_rdata[POS_SEL +: SEL_MAXW]   = sel;
            bus_rdata[POS_NDM]               = ndm;
            bus_rdata[POS_ACTIVE]            = active;
        end else if (bus_addr == INFO_ADDR) begin
            bus_rdata[POS_DSZ +: 4]          = DSZ_VAL;
        end
    end

    assign ndm_reset_o = ndm;
    assign dm_active_o = active;

    assert_strobes_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == CTRL_ADDR) |->
            (bus_rdata[POS_RESUME] == 1'b0 && bus_rdata[POS_ACK] == 1'b0 && bus_rdata[POS_ARRAY] == 1'b0));

    assert_dsz_limit_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == INFO_ADDR) |-> (bus_rdata[POS_DSZ +: 4] <= 4'd12));

endmodule

// File: tb/dbg_hart_ctl_tb.sv
module dbg_hart_ctl_tb;

    localparam int NH = 5;
    localparam int SL = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [6:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NH-1:0] halted_i = '0;
    logic [NH-1:0] halt_req_o, resume_req_o, hart_reset_o, have_reset_o;
    logic          ndm_reset_o, dm_active_o;

    always #2.5 clk = ~clk;

    dbg_hart_ctl #(.HARTSELLEN(SL), .NHARTS(NH), .DATA_WORDS(14)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .halted_i(halted_i),
        .halt_req_o(halt_req_o), .resume_req_o(resume_req_o),
        .hart_reset_o(hart_reset_o), .have_reset_o(have_reset_o),
        .ndm_reset_o(ndm_reset_o), .dm_active_o(dm_active_o)
    );

    typedef enum int {K_RD, K_HALT, K_RES, K_HRST, K_HAVE, K_NDM, K_ACT, K_VAL} kind_t;
    typedef struct {
        kind_t       kind;
        logic [31:0] exp;
        logic [31:0] val;
        string       tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    function automatic logic [31:0] observe(input item_t it);
        case (it.kind)
            K_RD:    return bus_rdata;
            K_HALT:  return 32'(halt_req_o);
            K_RES:   return 32'(resume_req_o);
            K_HRST:  return 32'(hart_reset_o);
            K_HAVE:  return 32'(have_reset_o);
            K_NDM:   return 32'(ndm_reset_o);
            K_ACT:   return 32'(dm_active_o);
            default: return it.val;
        endcase
    endfunction

    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = observe(it);
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_item(input kind_t k, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = k; it.exp = e; it.val = '0; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic expect_val(input logic [31:0] v, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = K_VAL; it.exp = e; it.val = v; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic next_cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, input logic [31:0] e, input string tag);
        bus_addr = a;
        expect_item(K_RD, e, tag);
    endtask

    function automatic logic [31:0] ctl(input bit h, input bit r, input bit hr, input bit ak,
                                        input int s, input bit nd, input bit ac);
        logic [31:0] w;
        w = '0;
        w[31] = h; w[30] = r; w[29] = hr; w[28] = ak;
        w[25:16] = 10'(s); w[1] = nd; w[0] = ac;
        return w;
    endfunction

    function automatic int count_low_ones(input logic [31:0] w);
        int n;
        n = 0;
        for (int i = 16; i < 26; i++) begin
            if (w[i]) n++;
            else break;
        end
        return n;
    endfunction

    initial begin
        #(5 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(7'h10, 32'h0, "R1 ctrl after reset");
        expect_item(K_HALT, 0, "R1 halt after reset");
        expect_item(K_HAVE, 0, "R1 have_reset after reset");
        expect_item(K_ACT, 0, "R1 active after reset");
        next_cyc();

        // R2 writes ignored while inactive
        wr(7'h10, 32'hFFFF_FFFE);
        rd(7'h10, 32'h0, "R2 inactive write ignored");
        expect_item(K_HALT, 0, "R2 inactive halt");
        expect_item(K_NDM, 0, "R2 inactive ndm");
        next_cyc();
        wr(7'h10, 32'h1);
        rd(7'h10, 32'h1, "R2 activate readback");
        expect_item(K_ACT, 1, "R2 active out");
        next_cyc();

        // R3 probe width
        wr(7'h10, ctl(0,0,0,0,10'h3ff,0,1));
        rd(7'h10, 32'h0007_0001, "R3 all-ones readback");
        next_cyc();
        bus_addr = 7'h10;
        #1;
        expect_val(32'(count_low_ones(bus_rdata)), 32'(SL), "R3 probed width");
        next_cyc();

        // R8 out-of-range index selects nothing
        wr(7'h10, ctl(1,0,1,0,7,0,1));
        expect_item(K_HALT, 0, "R8 halt with index 7");
        expect_item(K_HRST, 0, "R8 hart reset with index 7");
        rd(7'h10, 32'h0007_0001, "R8 readback index 7");
        next_cyc();

        // R4 per-hart halt levels
        wr(7'h10, ctl(1,0,0,0,2,0,1));
        expect_item(K_HALT, 32'b00100, "R4 halt hart2");
        rd(7'h10, 32'h8002_0001, "R4 readback halt hart2");
        next_cyc();
        wr(7'h10, ctl(1,0,0,0,0,0,1));
        expect_item(K_HALT, 32'b00101, "R4 halt hart0 keeps hart2");
        next_cyc();
        wr(7'h10, ctl(0,0,0,0,2,0,1));
        expect_item(K_HALT, 32'b00001, "R4 clear hart2 only");
        rd(7'h10, 32'h0002_0001, "R4 readback hart2 low");
        next_cyc();

        // R5 resume pulse gated by halted
        halted_i = 5'b00010;
        wr(7'h10, ctl(0,1,0,0,1,0,1));
        expect_item(K_RES, 32'b00010, "R5 resume pulse hart1");
        rd(7'h10, 32'h0001_0001, "R5 resume bit reads 0");
        next_cyc();
        expect_item(K_RES, 0, "R5 pulse one cycle");
        next_cyc();
        wr(7'h10, ctl(0,1,0,0,3,0,1));
        expect_item(K_RES, 0, "R5 no resume when not halted");
        next_cyc();

        // R6 / R7 hart reset and have-reset
        wr(7'h10, ctl(0,0,1,0,4,0,1));
        expect_item(K_HRST, 32'b10000, "R6 hart reset hart4");
        rd(7'h10, 32'h2004_0001, "R6 readback hart reset");
        next_cyc();
        wr(7'h10, ctl(0,0,0,0,4,0,1));
        expect_item(K_HRST, 0, "R6 hart reset released");
        expect_item(K_HAVE, 32'b10000, "R7 have_reset hart4");
        next_cyc();
        wr(7'h10, ctl(0,0,1,0,3,0,1));
        wr(7'h10, ctl(0,0,0,0,3,0,1));
        expect_item(K_HAVE, 32'b11000, "R7 have_reset hart3");
        next_cyc();
        wr(7'h10, ctl(0,0,0,1,4,0,1));
        expect_item(K_HAVE, 32'b01000, "R7 ack clears hart4 only");
        rd(7'h10, 32'h0004_0001, "R7 ack bit reads 0");
        next_cyc();

        // R9 ndm level and array bit
        wr(7'h10, ctl(0,0,0,0,0,1,1) | 32'h0400_0000);
        rd(7'h10, 32'h0000_0003, "R9 ndm stored, array bit 0");
        expect_item(K_NDM, 1, "R9 ndm output");
        expect_item(K_HALT, 0, "R4 hart0 halt cleared");
        next_cyc();

        // R10 info register and unmapped address
        rd(7'h12, 32'h0000_C000, "R10 info data size clamp");
        next_cyc();
        rd(7'h05, 32'h0, "R10 unmapped reads 0");
        next_cyc();

        // R2 deactivate clears everything, then inactive write ignored
        wr(7'h10, ctl(1,0,1,0,1,1,1));
        next_cyc();
        wr(7'h10, 32'h0);
        rd(7'h10, 32'h0, "R2 deactivate clears ctrl");
        expect_item(K_HALT, 0, "R2 deactivate halt");
        expect_item(K_HRST, 0, "R2 deactivate hart reset");
        expect_item(K_HAVE, 0, "R2 deactivate have_reset");
        expect_item(K_NDM, 0, "R2 deactivate ndm");
        next_cyc();
        wr(7'h10, 32'h8001_0000);
        expect_item(K_HALT, 0, "R2 inactive halt ignored");
        expect_item(K_ACT, 0, "R2 still inactive");
        // R11 same-cycle read
        rd(7'h10, 32'h0, "R11 combinational read");
        next_cyc();
        next_cyc();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule